// File: doc/BRIEF.md
# Halfword Register Bank Slave with Fixed Wait States

This block is a memory-mapped slave on a simple on-chip bus. It holds a bank of 32 sixteen-bit registers reached through a word address, so each address names one halfword. A bus master selects the block with `bus_sel` and drives one of two strobes: `bus_rd` to read or `bus_wr` to write. On a write, two byte-enable bits choose which bytes of the addressed register are updated. The bank also drives an interrupt request line. A write to the doorbell register sets it. A read of that same register clears it.

The parameter `WAIT_STATES` fixes the timing of every transfer. With 0, a transfer lasts one clock. Read data comes combinationally from the addressed register, and a write lands on the first rising edge. With 1, a transfer lasts two clocks. The first rising edge loads the read data into a register, and the second rising edge completes the transfer: it is the edge where the master samples the read data and where a write lands.

The timing is set by a small state machine with two states:
- **IDLE** waits for a select.
- **HOLD** is the wait-state cycle and exists only when `WAIT_STATES` is 1.

Its transitions are:
- **IDLE→HOLD** (start) is taken on a selected read or write when `WAIT_STATES` is 1.
- **IDLE→IDLE** (stay) is taken in every other case.
- **HOLD→IDLE** (complete) is always taken after one cycle.

With `WAIT_STATES` equal to 0, the machine never leaves IDLE. Every transfer completes in IDLE.

The master keeps address, strobes, byte enables and select steady for the whole transfer.

Top module: `slv_halfword_bank`

## Requirements
- R1: After an active-low reset, all 32 registers hold 0, `irq_req` is 0 and `bus_rdata` is 0.
- R2: `bus_rdata` is 0 in every cycle in which `bus_sel` or `bus_rd` is low.
- R3: With `WAIT_STATES`=0, during a cycle with `bus_sel` and `bus_rd` high, `bus_rdata` shows the register at `bus_addr` combinationally.
- R4: With `WAIT_STATES`=1, a read shows 0 in its first cycle. In its second cycle it shows the register value captured at the first rising edge.
- R5: With `WAIT_STATES`=0, a selected write updates the register at the first rising edge of the transfer.
- R6: With `WAIT_STATES`=1, nothing changes at the first rising edge of a write. The write takes effect at the second rising edge.
- R7: Byte lanes are little-endian. `bus_be[0]` enables bits 7..0 and `bus_be[1]` enables bits 15..8. A lane whose enable is low keeps its stored value.
- R8: Strobes have no effect while `bus_sel` is low: no register changes and `bus_rdata` stays 0.
- R9: A completed write to address 31 sets `irq_req` at its completing edge, whatever the byte enables.
- R10: A completed read of address 31 clears `irq_req` at its completing edge.
- R11: When read and write are both asserted in one transfer, the write commits and the read returns the value held before it. For address 31, setting the interrupt wins over clearing it.
- R12: Each address selects its own register. A write never changes any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Block select for the current transfer |
| bus_addr | input | 5 | Halfword register index |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading |
| irq_req | output | 1 | Interrupt request toward the processor |

## Verification
Two functions can land on the same completing edge: the interrupt set caused by a write to address 31 and the interrupt clear caused by a read of it. This happens when one transfer asserts both strobes. The bench drives such a transfer against both timing variants and checks three things:
- `bus_rdata` still shows the old contents of address 31.
- `irq_req` is high after the completing edge.
- A following plain read returns the new data and clears the request.

Byte-lane merging meets a new write in the same cycle as well. Each table write is immediately read back and compared with a lane-masked model.

// File: rtl/slv_pkg.sv
package slv_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } bus_state_e;

    // completion strobes produced by the timing machine
    typedef struct packed {
        logic wr;
        logic rd;
    } commit_t;

endpackage

// File: rtl/slv_bus_fsm.sv
module slv_bus_fsm
    import slv_pkg::*;
#(
    parameter int WAIT_STATES = 0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel,
    input  logic    rd,
    input  logic    wr,
    output commit_t commit,
    output logic    cap_en,
    output logic    drive_en
);

    localparam bit HAS_HOLD = (WAIT_STATES != 0);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       req;

    assign req = sel & (rd | wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = (HAS_HOLD && req) ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit   = '0;
        cap_en   = 1'b0;
        drive_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (HAS_HOLD) begin
                    cap_en = req;
                end else begin
                    commit.wr = sel & wr;
                    commit.rd = sel & rd;
                    drive_en  = sel & rd;
                end
            end
            ST_HOLD: begin
                commit.wr = sel & wr;
                commit.rd = sel & rd;
                drive_en  = sel & rd;
            end
            default: begin
                commit   = '0;
                cap_en   = 1'b0;
                drive_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slv_lane_regs.sv
module slv_lane_regs #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [LANES-1:0]  lane_we;

    for (genvar l = 0; l < LANES; l++) begin : g_lane_en
        assign lane_we[l] = we & be[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) begin
                    mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/slv_read_path.sv
module slv_read_path #(
    parameter int DATA_W      = 16,
    parameter int WAIT_STATES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              drive_en,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] dout
);

    if (WAIT_STATES == 0) begin : g_comb
        logic unused_cap;
        logic unused_clk;
        logic unused_rst;
        assign unused_cap = cap_en;
        assign unused_clk = clk;
        assign unused_rst = rst_n;
        assign dout = drive_en ? raw : '0;
    end else begin : g_reg
        logic [DATA_W-1:0] hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (cap_en) begin
                hold_q <= raw;
            end
        end
        assign dout = drive_en ? hold_q : '0;
    end

endmodule

// File: rtl/slv_irq_ctl.sv
module slv_irq_ctl #(
    parameter int ADDR_W   = 5,
    parameter int IRQ_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] addr,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] DOORBELL = ADDR_W'(IRQ_ADDR);

    logic hit;
    assign hit = (addr == DOORBELL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (hit && wr_done) begin
            irq <= 1'b1;
        end else if (hit && rd_done) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/slv_halfword_bank.sv
module slv_halfword_bank
    import slv_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int WAIT_STATES = 0,
    parameter int IRQ_ADDR    = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_req
);

    commit_t           commit;
    logic              cap_en;
    logic              drive_en;
    logic [DATA_W-1:0] cell_data;

    slv_bus_fsm #(.WAIT_STATES(WAIT_STATES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .commit   (commit),
        .cap_en   (cap_en),
        .drive_en (drive_en)
    );

    slv_lane_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit.wr),
        .addr  (bus_addr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .rdata (cell_data)
    );

    slv_read_path #(.DATA_W(DATA_W), .WAIT_STATES(WAIT_STATES)) u_rpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .drive_en (drive_en),
        .raw      (cell_data),
        .dout     (bus_rdata)
    );

    slv_irq_ctl #(.ADDR_W(ADDR_W), .IRQ_ADDR(IRQ_ADDR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_done (commit.wr),
        .rd_done (commit.rd),
        .addr    (bus_addr),
        .irq     (irq_req)
    );

endmodule

// File: rtl/slv_halfword_bank_chk.sv
module slv_halfword_bank_chk #(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int WAIT_STATES = 0,
    parameter int IRQ_ADDR    = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_req
);

    localparam logic [ADDR_W-1:0] DOORBELL = ADDR_W'(IRQ_ADDR);

    // R2
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_rd) |-> bus_rdata == '0);

    // R9
    irq_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(bus_sel && bus_wr && bus_addr == DOORBELL));

    // R10
    irq_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req) |-> $past(bus_sel && bus_rd && bus_addr == DOORBELL));

    // R8
    irq_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && (bus_rd || bus_wr)) |=> $stable(irq_req));

    if (WAIT_STATES != 0) begin : g_ws1
        // R4
        first_cycle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bus_sel && bus_rd) |-> bus_rdata == '0);
    end

endmodule

bind slv_halfword_bank slv_halfword_bank_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WAIT_STATES (WAIT_STATES),
    .IRQ_ADDR    (IRQ_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
);

// File: tb/slv_halfword_bank_tb_top.sv
module slv_halfword_bank_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // bus for the zero-wait instance
    logic        s0_sel = 0, s0_rd = 0, s0_wr = 0;
    logic [4:0]  s0_addr = '0;
    logic [1:0]  s0_be = '0;
    logic [15:0] s0_wdata = '0;
    logic [15:0] s0_rdata;
    logic        s0_irq;
    // bus for the one-wait instance
    logic        s1_sel = 0, s1_rd = 0, s1_wr = 0;
    logic [4:0]  s1_addr = '0;
    logic [1:0]  s1_be = '0;
    logic [15:0] s1_wdata = '0;
    logic [15:0] s1_rdata;
    logic        s1_irq;

    slv_halfword_bank #(.WAIT_STATES(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(s0_sel), .bus_addr(s0_addr),
        .bus_rd(s0_rd), .bus_wr(s0_wr), .bus_be(s0_be), .bus_wdata(s0_wdata),
        .bus_rdata(s0_rdata), .irq_req(s0_irq)
    );

    slv_halfword_bank #(.WAIT_STATES(1)) dut_w1_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(s1_sel), .bus_addr(s1_addr),
        .bus_rd(s1_rd), .bus_wr(s1_wr), .bus_be(s1_be), .bus_wdata(s1_wdata),
        .bus_rdata(s1_rdata), .irq_req(s1_irq)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // {addr, be, wdata}
    localparam logic [22:0] VEC [12] = '{
        {5'd0,  2'b11, 16'h1234},
        {5'd0,  2'b01, 16'hABCD},
        {5'd0,  2'b10, 16'h5600},
        {5'd0,  2'b00, 16'hFFFF},
        {5'd7,  2'b11, 16'hBEEF},
        {5'd7,  2'b10, 16'h0000},
        {5'd15, 2'b11, 16'h8001},
        {5'd16, 2'b01, 16'h0077},
        {5'd16, 2'b10, 16'h9900},
        {5'd30, 2'b11, 16'hFFFF},
        {5'd30, 2'b00, 16'h0000},
        {5'd1,  2'b11, 16'h0F0F}
    };

    logic [15:0] shadow [32];

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_bus(input int ws, input logic s, input logic r, input logic w,
                           input logic [4:0] a, input logic [1:0] b, input logic [15:0] d);
        if (ws == 0) begin
            s0_sel = s; s0_rd = r; s0_wr = w; s0_addr = a; s0_be = b; s0_wdata = d;
        end else begin
            s1_sel = s; s1_rd = r; s1_wr = w; s1_addr = a; s1_be = b; s1_wdata = d;
        end
    endtask

    // one transfer: first = rdata in first cycle, mid_irq = irq just before completing edge
    task automatic xfer(input int ws, input logic r, input logic w, input logic [4:0] a,
                        input logic [1:0] b, input logic [15:0] d,
                        output logic [15:0] got, output logic [15:0] first, output logic mid_irq);
        @(posedge clk); #1;
        set_bus(ws, 1'b1, r, w, a, b, d);
        @(negedge clk);
        first   = (ws == 0) ? s0_rdata : s1_rdata;
        mid_irq = (ws == 0) ? s0_irq : s1_irq;
        if (ws != 0) begin
            @(negedge clk);
            mid_irq = s1_irq;
        end
        got = (ws == 0) ? s0_rdata : s1_rdata;
        @(posedge clk); #1;
        set_bus(ws, 1'b0, 1'b0, 1'b0, 5'd0, 2'b00, 16'h0000);
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] b,
                                          input logic [15:0] d);
        return {b[1] ? d[15:8] : old[15:8], b[0] ? d[7:0] : old[7:0]};
    endfunction

    function automatic logic cur_irq(input int ws);
        return (ws == 0) ? s0_irq : s1_irq;
    endfunction

    initial begin
        logic [15:0] got, first;
        logic mi;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset-time outputs
        chk("R1 irq ws0", {15'd0, s0_irq}, 16'h0);
        chk("R1 irq ws1", {15'd0, s1_irq}, 16'h0);
        chk("R1 rdata ws0", s0_rdata, 16'h0);
        rst_n = 1'b1;

        for (int ws = 0; ws < 2; ws++) begin
            for (int i = 0; i < 32; i++) shadow[i] = 16'h0;
            // R1 all registers zero
            for (int i = 0; i < 32; i++) begin
                xfer(ws, 1, 0, 5'(i), 2'b11, 16'h0, got, first, mi);
                chk($sformatf("R1 ws%0d reg%0d", ws, i), got, 16'h0);
            end
            // table walk, R5/R6/R7 readback, R3/R4 read timing
            for (int v = 0; v < 12; v++) begin
                logic [4:0] a;
                logic [1:0] b;
                logic [15:0] d;
                {a, b, d} = VEC[v];
                xfer(ws, 0, 1, a, b, d, got, first, mi);
                shadow[a] = merge(shadow[a], b, d);
                xfer(ws, 1, 0, a, 2'b00, 16'h0, got, first, mi);
                chk($sformatf("R7 ws%0d vec%0d", ws, v), got, shadow[a]);
                if (ws == 0) chk("R3 same-cycle read", first, shadow[a]);
                else         chk("R4 first cycle zero", first, 16'h0);
            end
            // R12 other addresses untouched
            for (int i = 0; i < 31; i++) begin
                xfer(ws, 1, 0, 5'(i), 2'b11, 16'h0, got, first, mi);
                chk($sformatf("R12 ws%0d reg%0d", ws, i), got, shadow[i]);
            end
            // R8 strobes without select
            @(posedge clk); #1;
            set_bus(ws, 1'b0, 1'b1, 1'b1, 5'd2, 2'b11, 16'hFFFF);
            @(negedge clk);
            chk("R8 rdata unselected", (ws == 0) ? s0_rdata : s1_rdata, 16'h0);
            chk("R2 rdata unselected", (ws == 0) ? s0_rdata : s1_rdata, 16'h0);
            @(posedge clk); #1;
            set_bus(ws, 1'b0, 1'b0, 1'b0, 5'd0, 2'b00, 16'h0);
            xfer(ws, 1, 0, 5'd2, 2'b11, 16'h0, got, first, mi);
            chk("R8 no write unselected", got, 16'h0);
            // R9 doorbell write with no lanes, R6 timing
            xfer(ws, 0, 1, 5'd31, 2'b00, 16'h1111, got, first, mi);
            chk("R6 irq before completing edge", {15'd0, mi}, 16'h0);
            @(negedge clk);
            chk("R9 irq set", {15'd0, cur_irq(ws)}, 16'h1);
            // R10 read clears, data untouched by be=00
            xfer(ws, 1, 0, 5'd31, 2'b11, 16'h0, got, first, mi);
            chk("R7 be00 keeps reg31", got, 16'h0);
            chk("R10 irq held until edge", {15'd0, mi}, 16'h1);
            @(negedge clk);
            chk("R10 irq cleared", {15'd0, cur_irq(ws)}, 16'h0);
            // R11 read and write together on doorbell
            xfer(ws, 1, 1, 5'd31, 2'b11, 16'hC0DE, got, first, mi);
            chk("R11 old data returned", got, 16'h0);
            @(negedge clk);
            chk("R11 set wins", {15'd0, cur_irq(ws)}, 16'h1);
            xfer(ws, 1, 0, 5'd31, 2'b11, 16'h0, got, first, mi);
            chk("R11 write committed", got, 16'hC0DE);
            @(negedge clk);
            chk("R10 cleared after R11", {15'd0, cur_irq(ws)}, 16'h0);
        end

        // R1 reset again restores zeros
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        xfer(0, 1, 0, 5'd7, 2'b11, 16'h0, got, first, mi);
        chk("R1 reset clears reg7 ws0", got, 16'h0);
        xfer(1, 1, 0, 5'd7, 2'b11, 16'h0, got, first, mi);
        chk("R1 reset clears reg7 ws1", got, 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule